// File: doc/BRIEF.md
# Half-Bridge Gate Control Sequencer

This block sequences the two gate enables of one synchronous buck phase. It runs on a fast clock, and every time interval is counted in cycles of that clock. It takes a pre-decoded three-level PWM command, an enable and a driver-supply-good flag, and three current comparators: inductor current positive, high-side over-current and negative valley limit. The two gate enables it produces are never on together. A programmable dead time separates every hand-over from one gate to the other.

A mid-level PWM input counts as tri-state only after it has held for `TRI_CYC` samples. Once it counts, the high-side gate drops and the low-side gate falls back to diode emulation. Diode emulation also applies whenever PWM is low: the low-side gate conducts only while the current is positive. A positive over-current trip blanks the high-side gate until the next PWM cycle starts. A negative valley trip turns the low-side gate off and, after the dead time, forces the high-side gate on for `NEG_CYC` cycles. A neighbouring protection block receives one pulse per finished PWM cycle, either a trip pulse or a clean pulse, and can block the high-side gate through a force-off input.

States: `ST_OFF` (disabled), `ST_IDLE` (both gates off), `ST_DT_HS` / `ST_DT_LS` / `ST_DT_NEG` (dead time ahead of the high side, the low side, or the forced high-side pulse), `ST_HS`, `ST_LS`, `ST_NEG_HS`.

Transitions:
- Any state goes to `ST_OFF` when enable or supply-good is low.
- `ST_OFF` goes to `ST_DT_LS` when both return.
- `ST_IDLE` goes to `ST_DT_HS` on a high-side request, or to `ST_LS` when the current is positive.
- `ST_DT_HS` goes to `ST_HS` when its count ends, or back to `ST_IDLE` if the request is withdrawn.
- `ST_HS` goes to `ST_DT_LS` when the request ends.
- `ST_DT_LS`, when its count ends, goes to `ST_HS` if a request is present, otherwise to `ST_LS` if the current is positive, otherwise to `ST_IDLE`.
- `ST_LS` goes to `ST_DT_NEG` on a valley trip, to `ST_DT_HS` on a request, and to `ST_IDLE` when the current is no longer positive, in that priority.
- `ST_DT_NEG` goes to `ST_NEG_HS`, or to `ST_IDLE` if the high side is blocked.
- `ST_NEG_HS` goes to `ST_DT_LS` when the pulse ends, or early on force-off or over-current.

Top module: `hb_gate_seq`

## Requirements
- R1: When `en_i` or `supply_ok_i` is low at a clock edge, both gate enables are low after that edge. After both return, both gates stay off for the dead time before any gate turns on.
- R2: `hs_on_o` and `ls_on_o` are never high in the same cycle.
- R3: Let the dead time D be `dt_cyc_i`, with 0 treated as 1. Whenever one gate turns on after the other gate was the last one on, both gates have been off for at least D cycles. A high-side turn-on from idle therefore appears 1+D edges after the high command is first sampled.
- R4: `pwm_lvl_i` is encoded as 2'b00 for low, 2'b01 for high, and 2'b10 or 2'b11 for mid. While PWM is high and nothing blocks it, the high-side gate is on. When PWM goes low, the high side drops at the next edge.
- R5: A mid level held for fewer than `TRI_CYC` consecutive samples keeps the previous firm command and does not start a new PWM cycle. If it holds for `TRI_CYC` samples, the high side drops at the following edge.
- R6: With PWM low or tri-state, the low side is on only while `il_pos_i` is high. It turns off at the first edge that samples `il_pos_i` low.
- R7: When `ocp_i` is sampled high, the high side is off after that edge. It stays off for the rest of the PWM cycle even though PWM remains high, and resumes after the next low-to-high PWM change.
- R8: When `neg_lim_i` is sampled high while the low side is on, the low side is off after that edge. After D cycles the high side is on for exactly `NEG_CYC` cycles, then the normal dead time follows.
- R9: At each PWM cycle start (a high sample after a low or a tri-state), exactly one of `ilim_trip_o` and `cyc_ok_o` pulses for one cycle. Which one depends on whether an over-current trip occurred in the cycle that just ended. No pulse reports the first cycle after enable.
- R10: While `force_off_i` is high, the high side is off after every edge, and the low side still follows diode emulation.
- R11: A negative valley trip never produces `ilim_trip_o`. The cycle containing it reports `cyc_ok_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Phase enable |
| supply_ok_i | input | 1 | Gate driver supply good |
| pwm_lvl_i | input | 2 | Decoded PWM level: 00 low, 01 high, 1x mid |
| dt_cyc_i | input | DT_W | Dead time in clock cycles (0 acts as 1) |
| il_pos_i | input | 1 | Inductor current positive comparator |
| ocp_i | input | 1 | High-side positive over-current comparator |
| neg_lim_i | input | 1 | Negative valley-current comparator |
| force_off_i | input | 1 | High-side block from the protection block |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| ilim_trip_o | output | 1 | One-cycle pulse: finished PWM cycle had a current-limit trip |
| cyc_ok_o | output | 1 | One-cycle pulse: finished PWM cycle had no trip |

## Verification
Gate reactions to the comparators, to force-off and to a PWM drop appear after the single edge that samples the input. Turn-ons that need a dead time appear 1+D edges after the request. Tri-state takes `TRI_CYC`+1 edges, and the forced high-side pulse spans `NEG_CYC` edges. Report pulses appear after the edge that samples the new high level and are gone one edge later. The bench drives and samples on falling edges and advances an exact number of edges, computed by a bench function from D, before each comparison. It then checks the cycle before the expected change as well as the cycle of the change.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_DT_HS,
        ST_HS,
        ST_DT_LS,
        ST_LS,
        ST_DT_NEG,
        ST_NEG_HS
    } seq_state_t;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_HIGH = 2'b01;

endpackage

// File: rtl/hb_tri_qual.sv
module hb_tri_qual #(
    parameter int TRI_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic is_mid,
    output logic tri_ok
);
    localparam int TQ_W = $clog2(TRI_CYC + 1);
    localparam logic [TQ_W-1:0] TQ_MAX = TQ_W'(TRI_CYC);

    logic [TQ_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !is_mid) begin
            cnt_q <= '0;
        end else if (cnt_q != TQ_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tri_ok = (cnt_q == TQ_MAX);

endmodule

// File: rtl/hb_hold_timer.sv
module hb_hold_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > TW'(1)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q <= TW'(1));

endmodule

// File: rtl/hb_cycle_report.sv
module hb_cycle_report (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic boundary,
    input  logic trip_set,
    output logic blk,
    output logic trip_o,
    output logic ok_o
);
    logic flag_q;
    logic valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            valid_q <= 1'b0;
            trip_o  <= 1'b0;
            ok_o    <= 1'b0;
        end else if (!run) begin
            flag_q  <= 1'b0;
            valid_q <= 1'b0;
            trip_o  <= 1'b0;
            ok_o    <= 1'b0;
        end else begin
            trip_o <= boundary && valid_q && flag_q;
            ok_o   <= boundary && valid_q && !flag_q;
            if (boundary) begin
                valid_q <= 1'b1;
                flag_q  <= trip_set;
            end else if (trip_set) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign blk = flag_q && !boundary;

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_seq_pkg::*;
#(
    parameter int DT_W    = 4,
    parameter int TRI_CYC = 6,
    parameter int NEG_CYC = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            supply_ok_i,
    input  logic [1:0]      pwm_lvl_i,
    input  logic [DT_W-1:0] dt_cyc_i,
    input  logic            il_pos_i,
    input  logic            ocp_i,
    input  logic            neg_lim_i,
    input  logic            force_off_i,
    output logic            hs_on_o,
    output logic            ls_on_o,
    output logic            ilim_trip_o,
    output logic            cyc_ok_o
);
    localparam int NC_W = $clog2(NEG_CYC + 1);
    localparam int TW   = (NC_W > DT_W) ? NC_W : DT_W;

    seq_state_t state_q, state_n;

    logic run, is_mid, is_hi, is_lo;
    logic last_hi_q, tri_ok, boundary, blk;
    logic want_hs, hs_req, trip_set;
    logic tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;

    assign run    = en_i && supply_ok_i;
    assign is_mid = pwm_lvl_i[1];
    assign is_hi  = (pwm_lvl_i == LVL_HIGH);
    assign is_lo  = (pwm_lvl_i == LVL_LOW);

    // last firm PWM level, held across a mid level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_hi_q <= 1'b0;
        end else if (!run) begin
            last_hi_q <= 1'b0;
        end else if (is_hi) begin
            last_hi_q <= 1'b1;
        end else if (is_lo) begin
            last_hi_q <= 1'b0;
        end
    end

    hb_tri_qual #(.TRI_CYC(TRI_CYC)) u_tri (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .is_mid (is_mid),
        .tri_ok (tri_ok)
    );

    assign boundary = run && is_hi && (!last_hi_q || tri_ok);
    assign trip_set = ocp_i && (state_q == ST_HS);

    hb_cycle_report u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .boundary (boundary),
        .trip_set (trip_set),
        .blk      (blk),
        .trip_o   (ilim_trip_o),
        .ok_o     (cyc_ok_o)
    );

    assign want_hs = is_hi || (is_mid && last_hi_q && !tri_ok);
    assign hs_req  = want_hs && !force_off_i && !ocp_i && !blk;

    // shared interval timer: dead times and the forced high-side pulse
    assign tmr_load = (state_n != state_q) &&
                      ((state_n == ST_DT_HS) || (state_n == ST_DT_LS) ||
                       (state_n == ST_DT_NEG) || (state_n == ST_NEG_HS));
    assign tmr_val  = (state_n == ST_NEG_HS) ? TW'(NEG_CYC) : TW'(dt_cyc_i);

    hb_hold_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        if (!run) begin
            state_n = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_n = ST_DT_LS;
                end
                ST_IDLE: begin
                    if (hs_req) begin
                        state_n = ST_DT_HS;
                    end else if (il_pos_i && !neg_lim_i) begin
                        state_n = ST_LS;
                    end
                end
                ST_DT_HS: begin
                    if (!hs_req) begin
                        state_n = ST_IDLE;
                    end else if (tmr_done) begin
                        state_n = ST_HS;
                    end
                end
                ST_HS: begin
                    if (!hs_req) begin
                        state_n = ST_DT_LS;
                    end
                end
                ST_DT_LS: begin
                    if (tmr_done) begin
                        if (hs_req) begin
                            state_n = ST_HS;
                        end else if (il_pos_i && !neg_lim_i) begin
                            state_n = ST_LS;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_LS: begin
                    if (neg_lim_i) begin
                        state_n = ST_DT_NEG;
                    end else if (hs_req) begin
                        state_n = ST_DT_HS;
                    end else if (!il_pos_i) begin
                        state_n = ST_IDLE;
                    end
                end
                ST_DT_NEG: begin
                    if (force_off_i || ocp_i) begin
                        state_n = ST_IDLE;
                    end else if (tmr_done) begin
                        state_n = ST_NEG_HS;
                    end
                end
                ST_NEG_HS: begin
                    if (force_off_i || ocp_i || tmr_done) begin
                        state_n = ST_DT_LS;
                    end
                end
                default: state_n = ST_OFF;
            endcase
        end
    end

    // gate outputs decoded from the state register
    always_comb begin
        hs_on_o = (state_q == ST_HS) || (state_q == ST_NEG_HS);
        ls_on_o = (state_q == ST_LS);
    end

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
    parameter int DT_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en_i,
    input logic            supply_ok_i,
    input logic [DT_W-1:0] dt_cyc_i,
    input logic            il_pos_i,
    input logic            ocp_i,
    input logic            force_off_i,
    input logic            hs_on_o,
    input logic            ls_on_o,
    input logic            ilim_trip_o,
    input logic            cyc_ok_o
);
    logic [DT_W:0]   gap_q;
    logic            hs_d, ls_d, last_hs_q;
    logic [DT_W-1:0] dt_eff;

    assign dt_eff = (dt_cyc_i == '0) ? DT_W'(1) : dt_cyc_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= '1;
            hs_d      <= 1'b0;
            ls_d      <= 1'b0;
            last_hs_q <= 1'b0;
        end else begin
            hs_d <= hs_on_o;
            ls_d <= ls_on_o;
            if (hs_on_o || ls_on_o) begin
                gap_q <= '0;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
            if (hs_on_o) begin
                last_hs_q <= 1'b1;
            end else if (ls_on_o) begin
                last_hs_q <= 1'b0;
            end
        end
    end

    // R1
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && supply_ok_i) |=> (!hs_on_o && !ls_on_o));

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on_o && ls_on_o));

    // R3
    hs_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on_o && !hs_d && !last_hs_q) |-> (gap_q >= {1'b0, dt_eff}));

    // R3
    ls_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on_o && !ls_d && last_hs_q) |-> (gap_q >= {1'b0, dt_eff}));

    // R6
    de_zero_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on_o && !il_pos_i) |=> !ls_on_o);

    // R7
    ocp_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_i |=> !hs_on_o);

    // R10
    force_blocks_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_i |=> !hs_on_o);

    // R9
    report_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ilim_trip_o, cyc_ok_o}));

    // R9
    report_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_trip_o || cyc_ok_o) |=> !(ilim_trip_o || cyc_ok_o));

endmodule

bind hb_gate_seq hb_gate_seq_chk #(.DT_W(DT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .supply_ok_i (supply_ok_i),
    .dt_cyc_i    (dt_cyc_i),
    .il_pos_i    (il_pos_i),
    .ocp_i       (ocp_i),
    .force_off_i (force_off_i),
    .hs_on_o     (hs_on_o),
    .ls_on_o     (ls_on_o),
    .ilim_trip_o (ilim_trip_o),
    .cyc_ok_o    (cyc_ok_o)
);

// File: tb/tb_hb_gate_seq.sv
module tb_hb_gate_seq;
    localparam int DT_W    = 4;
    localparam int TRI_CYC = 6;
    localparam int NEG_CYC = 25;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            en, sok, il_pos, ocp, neg, foff;
    logic [1:0]      lvl;
    logic [DT_W-1:0] dt;
    logic            hs, ls, trip, okp;

    int nchk = 0;
    int errs = 0;

    always #4 clk = ~clk;

    hb_gate_seq #(.DT_W(DT_W), .TRI_CYC(TRI_CYC), .NEG_CYC(NEG_CYC)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .supply_ok_i (sok),
        .pwm_lvl_i   (lvl),
        .dt_cyc_i    (dt),
        .il_pos_i    (il_pos),
        .ocp_i       (ocp),
        .neg_lim_i   (neg),
        .force_off_i (foff),
        .hs_on_o     (hs),
        .ls_on_o     (ls),
        .ilim_trip_o (trip),
        .cyc_ok_o    (okp)
    );

    // edges from a request to a dead-time-guarded turn-on
    function automatic int on_delay(input int d);
        return 1 + ((d == 0) ? 1 : d);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        int d;
        int r;
        logic prev_run;
        rst_n = 1'b0; en = 0; sok = 0; il_pos = 0; ocp = 0; neg = 0; foff = 0;
        lvl = 2'b00; dt = 4'd3;
        r = $urandom(32'd20240611);
        d = on_delay(3);
        step(3);
        chk("R1", "reset hs", hs, 1'b0);
        chk("R1", "reset ls", ls, 1'b0);
        chk("R9", "reset trip", trip, 1'b0);
        chk("R9", "reset ok", okp, 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R1", "disabled hs", hs, 1'b0);

        // enable, PWM low, no current
        en = 1; sok = 1; lvl = 2'b00;
        step(d);
        chk("R6", "no current ls", ls, 1'b0);
        il_pos = 1; step(1);
        chk("R6", "positive current ls on", ls, 1'b1);
        il_pos = 0; step(1);
        chk("R6", "zero cross ls off", ls, 1'b0);

        // first PWM high: no report, dead time then high side
        lvl = 2'b01; il_pos = 1; step(1);
        chk("R9", "first cycle no trip", trip, 1'b0);
        chk("R9", "first cycle no ok", okp, 1'b0);
        step(d - 2);
        chk("R4", "hs before dead time", hs, 1'b0);
        step(1);
        chk("R4", "hs on", hs, 1'b1);
        lvl = 2'b00; step(1);
        chk("R4", "hs off on low", hs, 1'b0);
        step(d - 2);
        chk("R3", "ls held in dead time", ls, 1'b0);
        step(1);
        chk("R3", "ls after dead time", ls, 1'b1);

        // second cycle: clean report
        lvl = 2'b01; step(1);
        chk("R9", "ok pulse", okp, 1'b1);
        chk("R9", "no trip pulse", trip, 1'b0);
        step(1);
        chk("R9", "ok single cycle", okp, 1'b0);
        step(d - 2);
        chk("R4", "hs on again", hs, 1'b1);

        // over-current in the cycle
        ocp = 1; step(1); ocp = 0;
        chk("R7", "hs cut by ocp", hs, 1'b0);
        step(12);
        chk("R7", "hs stays off in cycle", hs, 1'b0);
        chk("R7", "ls diode emulation", ls, 1'b1);
        lvl = 2'b00; step(2);
        lvl = 2'b01; step(1);
        chk("R9", "trip pulse", trip, 1'b1);
        chk("R9", "no ok with trip", okp, 1'b0);
        step(d - 1);
        chk("R7", "hs resumes next cycle", hs, 1'b1);

        // short mid glitch
        lvl = 2'b10; step(3);
        chk("R5", "short mid keeps hs", hs, 1'b1);
        lvl = 2'b01; step(1);
        chk("R5", "short mid hs", hs, 1'b1);
        chk("R5", "short mid no new cycle", okp | trip, 1'b0);
        // qualified tri-state
        lvl = 2'b11; step(TRI_CYC);
        chk("R5", "hs before tri qualifies", hs, 1'b1);
        step(1);
        chk("R5", "hs off on tri", hs, 1'b0);
        step(d - 2);
        chk("R5", "ls waits dead time", ls, 1'b0);
        step(1);
        chk("R5", "ls diode emulation in tri", ls, 1'b1);
        il_pos = 0; step(1);
        chk("R6", "tri zero cross", ls, 1'b0);

        // negative valley limit
        lvl = 2'b00; il_pos = 1; step(1);
        chk("R6", "ls on low", ls, 1'b1);
        neg = 1; step(1); neg = 0;
        chk("R8", "ls off on valley", ls, 1'b0);
        step(d - 2);
        chk("R8", "hs waits dead time", hs, 1'b0);
        step(1);
        chk("R8", "forced hs on", hs, 1'b1);
        step(NEG_CYC - 1);
        chk("R8", "forced hs last cycle", hs, 1'b1);
        step(1);
        chk("R8", "forced hs ends", hs, 1'b0);
        step(d - 2);
        chk("R8", "ls waits after pulse", ls, 1'b0);
        step(1);
        chk("R8", "ls back", ls, 1'b1);
        lvl = 2'b01; step(1);
        chk("R11", "valley gives ok", okp, 1'b1);
        chk("R11", "valley no trip", trip, 1'b0);
        step(d - 1);
        chk("R4", "hs on after valley cycle", hs, 1'b1);

        // force-off
        foff = 1; step(1);
        chk("R10", "force cuts hs", hs, 1'b0);
        step(d + 2);
        chk("R10", "hs blocked", hs, 1'b0);
        chk("R10", "ls still emulates", ls, 1'b1);
        il_pos = 0; step(1);
        chk("R10", "ls zero cross under force", ls, 1'b0);
        foff = 0; step(d - 1);
        chk("R10", "release waits dead time", hs, 1'b0);
        step(1);
        chk("R10", "hs after release", hs, 1'b1);

        // disable paths
        en = 0; step(1);
        chk("R1", "enable low hs", hs, 1'b0);
        chk("R1", "enable low ls", ls, 1'b0);
        en = 1; step(d - 1);
        chk("R1", "restart waits dead time", hs, 1'b0);
        step(1);
        chk("R1", "restart hs", hs, 1'b1);
        sok = 0; step(1);
        chk("R1", "supply bad hs", hs, 1'b0);
        sok = 1;

        // zero dead time behaves as one cycle
        lvl = 2'b00; step(d + 3);
        dt = 4'd0;
        lvl = 2'b01; step(on_delay(0) - 1);
        chk("R3", "zero dead time still one cycle", hs, 1'b0);
        step(1);
        chk("R3", "zero dead time hs", hs, 1'b1);

        // constrained random run
        dt = 4'd2;
        prev_run = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            en     = (($urandom % 32) != 0);
            sok    = (($urandom % 32) != 0);
            lvl    = 2'($urandom % 4);
            il_pos = (($urandom % 3) != 0);
            ocp    = (($urandom % 10) == 0);
            neg    = (($urandom % 12) == 0);
            foff   = (($urandom % 16) == 0);
            prev_run = en && sok;
            step(1);
            chk("R2", "random overlap", hs && ls, 1'b0);
            if (!prev_run) begin
                chk("R1", "random disabled", hs || ls, 1'b0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

endmodule